// File: doc/BRIEF.md
# Digital Zero-Crossing Clock Synthesizer

This block makes a square-wave clock with no analog parts. A numerically controlled oscillator adds a tuning word to a 32-bit phase register on every system clock. The upper phase bits select a signed sine sample from a table of constants. The samples pass through a fixed lowpass FIR that smooths the table steps. A sign-change stage then does the job of an analog comparator: it places each output edge at the zero crossing of the filtered wave. The most significant phase bit alone has the correct frequency, but it jitters by up to one full clock, so the block does not use it.

Edges are placed to half a system clock. Each clock the block presents two bits, one for each half of the clock period, to feed a double-data-rate output register. At a 160 MHz system clock, half-clock placement limits peak-to-peak jitter to about 3 ns. RMS jitter is that figure divided by the square root of 12. The output is a free-running stream with a valid flag and no ready input, because a clock cannot be held back. A downstream stage must accept a pair on every cycle in which valid is high.

A new frequency is taken only when the load strobe is high. The phase register carries on from its current value, so a retune causes no phase step.

Top module: `dds_edge_clkgen`

## Requirements
- R1: While reset is high, and after reset falls until the 20th rising clock edge, `edge_valid` is 0. It becomes 1 on the 20th edge and stays 1 until the next reset. A reset asserted during operation clears it after one edge.
- R2: Whenever `edge_valid` is 0, both bits of `edge_bits` are 0.
- R3: With tuning word T loaded, the number of rising output edges in W clocks is T·W/2^32, within ±1.
- R4: `tune_word` is taken only in a cycle where `tune_load` is 1. It takes part in the next phase addition. In other cycles the input has no effect on the output frequency.
- R5: `edge_bits[0]` is the level in the first half of the clock and `edge_bits[1]` the level in the second half. When the two differ, the edge lies at mid-clock and `edge_bits[0]` equals the previous clock's `edge_bits[1]`.
- R6: For a tuning word whose period is not a whole number of clocks, some output edges fall at mid-clock, in clocks where the two bits differ.
- R7: The output is high for 40% to 60% of the half-clock slots over a long window.
- R8: The spacing between successive rising edges, counted in half-clock slots, stays within ±2 slots of 2·2^32/T.
- R9: An edge is placed in the first half of the clock when the filtered sample after the crossing is at least as far from zero as the sample before it. Otherwise it is placed at mid-clock. Zero counts as positive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| tune_word | input | 32 | Phase increment per clock |
| tune_load | input | 1 | Takes `tune_word` when high |
| edge_bits | output | 2 | Output level for the first half (bit 0) and the second half (bit 1) of the clock |
| edge_valid | output | 1 | High once the pipeline holds real samples |

## Verification
A loaded tuning word enters the phase addition on the same edge. Its effect reaches `edge_bits` about 20 clocks later, after the table, 15 filter taps, the filter sum, the previous-sample register and the output register. The bench therefore waits 60 clocks after each load before it counts edges. `edge_valid` is due on exactly the 20th edge after reset falls, and a mid-run reset is due to clear it after one edge. All outputs are sampled on the falling clock edge, away from the edge that updates them. Frequency, duty and spacing are judged over 2000-clock windows, with tolerances derived from the half-clock placement rule.

// File: rtl/dds_pkg.sv
package dds_pkg;
  localparam int FIR_TAPS   = 15;
  localparam int FIR_GROWTH = 8;

  // Symmetric half-band style lowpass coefficients (DC gain 60).
  function automatic int fir_coef(input int k);
    case (k)
      0, 14:   return -1;
      2, 12:   return 3;
      4, 10:   return -8;
      6, 8:    return 20;
      7:       return 32;
      default: return 0;
    endcase
  endfunction

  // Rational sine approximation for one quarter wave.
  // idx runs 0..half/2 across a half wave of length half.
  function automatic int quarter_mag(input int idx, input int half, input int amp);
    longint p;
    longint h;
    longint q;
    p = longint'(idx);
    h = longint'(half);
    q = p * (h - p);
    return int'((longint'(amp) * 16 * q) / (5 * h * h - 4 * q));
  endfunction
endpackage

// File: rtl/dds_phase_acc.sv
module dds_phase_acc #(
  parameter int ACC_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [ACC_W-1:0] tune_word,
  input  logic             tune_load,
  output logic [ACC_W-1:0] phase
);
  logic [ACC_W-1:0] step_q;
  logic [ACC_W-1:0] step_use;

  assign step_use = tune_load ? tune_word : step_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      step_q <= '0;
      phase  <= '0;
    end else begin
      step_q <= step_use;
      phase  <= phase + step_use;
    end
  end
endmodule

// File: rtl/dds_sine_lut.sv
module dds_sine_lut #(
  parameter int ADDR_W = 10,
  parameter int SAMP_W = 12
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [ADDR_W-1:0]        addr,
  output logic signed [SAMP_W-1:0] sample
);
  localparam int HALF  = 2 ** (ADDR_W - 1);
  localparam int QBITS = ADDR_W - 2;
  localparam int QLEN  = 2 ** QBITS;
  localparam int IDX_W = QBITS + 1;
  localparam int MAG_W = SAMP_W - 1;
  localparam int AMP   = 2 ** (SAMP_W - 1) - 1;

  logic [MAG_W-1:0] qtab [QLEN+1];

  for (genvar g = 0; g <= QLEN; g++) begin : g_qtab
    assign qtab[g] = MAG_W'(dds_pkg::quarter_mag(g, HALF, AMP));
  end

  logic             neg_half;
  logic             second_q;
  logic [QBITS-1:0] q_off;
  logic [IDX_W-1:0] idx;
  logic [MAG_W-1:0] mag;
  logic signed [SAMP_W-1:0] mag_s;

  assign neg_half = addr[ADDR_W-1];
  assign second_q = addr[ADDR_W-2];
  assign q_off    = addr[QBITS-1:0];
  assign idx      = second_q ? (IDX_W'(QLEN) - IDX_W'(q_off)) : IDX_W'(q_off);
  assign mag      = qtab[idx];
  assign mag_s    = $signed({1'b0, mag});

  always_ff @(posedge clk) begin
    if (rst) sample <= '0;
    else     sample <= neg_half ? -mag_s : mag_s;
  end
endmodule

// File: rtl/dds_fir.sv
module dds_fir #(
  parameter int IN_W  = 12,
  parameter int OUT_W = 20
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic signed [IN_W-1:0]  x,
  output logic signed [OUT_W-1:0] y
);
  localparam int TAPS  = dds_pkg::FIR_TAPS;
  localparam int PAIRS = TAPS / 2;
  localparam int MID   = TAPS / 2;

  logic signed [IN_W-1:0]  tap_q [TAPS];
  logic signed [OUT_W-1:0] pre   [PAIRS];
  logic signed [OUT_W-1:0] sum_c;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < TAPS; i++) tap_q[i] <= '0;
    end else begin
      tap_q[0] <= x;
      for (int i = 1; i < TAPS; i++) tap_q[i] <= tap_q[i-1];
    end
  end

  for (genvar g = 0; g < PAIRS; g++) begin : g_pre
    assign pre[g] = OUT_W'(tap_q[g]) + OUT_W'(tap_q[TAPS-1-g]);
  end

  always_comb begin
    logic signed [OUT_W-1:0] c;
    sum_c = OUT_W'(tap_q[MID]) * OUT_W'(dds_pkg::fir_coef(MID));
    for (int i = 0; i < PAIRS; i++) begin
      c     = OUT_W'(dds_pkg::fir_coef(i));
      sum_c = sum_c + pre[i] * c;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) y <= '0;
    else     y <= sum_c;
  end
endmodule

// File: rtl/dds_edge_place.sv
module dds_edge_place #(
  parameter int Y_W = 20
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic signed [Y_W-1:0] y,
  output logic [1:0]            half_bits
);
  logic signed [Y_W-1:0] y_prev;
  logic signed [Y_W:0]   pair_sum;
  logic                  s_prev;
  logic                  s_cur;
  logic                  crossing;
  logic                  level_new;
  logic                  first_half;

  assign s_prev     = y_prev[Y_W-1];
  assign s_cur      = y[Y_W-1];
  assign crossing   = s_prev ^ s_cur;
  assign pair_sum   = (Y_W+1)'(y_prev) + (Y_W+1)'(y);
  assign level_new  = ~s_cur;
  // sum >= 0 on rising: crossing near earlier sample -> early edge
  assign first_half = crossing ? ~pair_sum[Y_W] : level_new;

  always_ff @(posedge clk) begin
    if (rst) begin
      y_prev    <= '0;
      half_bits <= '0;
    end else begin
      y_prev    <= y;
      half_bits <= {level_new, first_half};
    end
  end
endmodule

// File: rtl/dds_edge_clkgen.sv
module dds_edge_clkgen #(
  parameter int ACC_W  = 32,
  parameter int LUT_W  = 10,
  parameter int SAMP_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [ACC_W-1:0] tune_word,
  input  logic             tune_load,
  output logic [1:0]       edge_bits,
  output logic             edge_valid
);
  localparam int Y_W    = SAMP_W + dds_pkg::FIR_GROWTH;
  localparam int FILL   = dds_pkg::FIR_TAPS + 5;
  localparam int FILL_W = $clog2(FILL + 1);

  logic [ACC_W-1:0]         phase;
  logic signed [SAMP_W-1:0] sample;
  logic signed [Y_W-1:0]    filt;
  logic [1:0]               raw_bits;
  logic [FILL_W-1:0]        fill_cnt;

  dds_phase_acc #(.ACC_W(ACC_W)) acc_i (
    .clk(clk), .rst(rst), .tune_word(tune_word), .tune_load(tune_load), .phase(phase)
  );

  dds_sine_lut #(.ADDR_W(LUT_W), .SAMP_W(SAMP_W)) lut_i (
    .clk(clk), .rst(rst), .addr(phase[ACC_W-1 -: LUT_W]), .sample(sample)
  );

  dds_fir #(.IN_W(SAMP_W), .OUT_W(Y_W)) fir_i (
    .clk(clk), .rst(rst), .x(sample), .y(filt)
  );

  dds_edge_place #(.Y_W(Y_W)) place_i (
    .clk(clk), .rst(rst), .y(filt), .half_bits(raw_bits)
  );

  always_ff @(posedge clk) begin
    if (rst)                   fill_cnt <= '0;
    else if (fill_cnt != FILL) fill_cnt <= fill_cnt + 1'b1;
  end

  assign edge_valid = (fill_cnt == FILL_W'(FILL));
  assign edge_bits  = edge_valid ? raw_bits : 2'b00;
endmodule

// File: rtl/dds_edge_clkgen_chk.sv
module dds_edge_clkgen_chk (
  input logic       clk,
  input logic       rst,
  input logic [1:0] edge_bits,
  input logic       edge_valid
);
  // R1: valid is sticky once raised
  assert_valid_sticky_R1: assert property (@(posedge clk) disable iff (rst)
    edge_valid |=> edge_valid);

  // R1: a reset clears valid on the next edge
  assert_reset_clears_R1: assert property (@(posedge clk)
    rst |=> !edge_valid);

  // R2: quiet output while invalid
  assert_quiet_invalid_R2: assert property (@(posedge clk) disable iff (rst)
    !edge_valid |-> edge_bits == 2'b00);

  // R5: a mid-clock edge continues the previous late level
  assert_mid_edge_cont_R5: assert property (@(posedge clk) disable iff (rst)
    (edge_valid && $past(edge_valid) && (edge_bits[0] != edge_bits[1]))
      |-> edge_bits[0] == $past(edge_bits[1]));
endmodule

bind dds_edge_clkgen dds_edge_clkgen_chk chk_i (
  .clk(clk), .rst(rst), .edge_bits(edge_bits), .edge_valid(edge_valid)
);

// File: tb/dds_edge_clkgen_tb_top.sv
`timescale 1ns/1ps
module dds_edge_clkgen_tb_top;
  localparam int NVEC = 4;
  localparam int WIN  = 2000;
  // {tuning word, expected rising edges per WIN clocks}
  localparam logic [63:0] VEC [NVEC] = '{
    {32'd67108864,  32'd31},
    {32'd214748365, 32'd100},
    {32'd780903145, 32'd364},
    {32'd42949673,  32'd20}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] tune_word = '0;
  logic        tune_load = 1'b0;
  logic [1:0]  edge_bits;
  logic        edge_valid;
  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  dds_edge_clkgen dut_i (
    .clk(clk), .rst(rst), .tune_word(tune_word), .tune_load(tune_load),
    .edge_bits(edge_bits), .edge_valid(edge_valid)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic load_word(input logic [31:0] w);
    tune_word = w;
    tune_load = 1'b1;
    @(negedge clk);
    tune_load = 1'b0;
  endtask

  task automatic measure(output int rises, output int highs, output int min_sp,
                         output int max_sp, output int splits, output int bad_mid);
    int  slot;
    int  last;
    bit  prevb;
    bit  prev_late;
    rises = 0; highs = 0; min_sp = 1 << 30; max_sp = 0; splits = 0; bad_mid = 0;
    slot = 0; last = -1;
    prevb = edge_bits[1];
    prev_late = edge_bits[1];
    for (int c = 0; c < WIN; c++) begin
      @(negedge clk);
      if (edge_bits[0] != edge_bits[1]) begin
        splits++;
        if (edge_bits[0] != prev_late) bad_mid++;
      end
      prev_late = edge_bits[1];
      for (int h = 0; h < 2; h++) begin
        if (edge_bits[h]) highs++;
        if (edge_bits[h] && !prevb) begin
          rises++;
          if (last >= 0) begin
            if (slot - last < min_sp) min_sp = slot - last;
            if (slot - last > max_sp) max_sp = slot - last;
          end
          last = slot;
        end
        prevb = edge_bits[h];
        slot++;
      end
    end
  endtask

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int n;
    bit noisy;
    int rises, highs, min_sp, max_sp, splits, bad_mid;
    repeat (4) @(negedge clk);
    check(edge_valid == 1'b0, "R1", "valid in reset", edge_valid, 0);
    check(edge_bits == 2'b00, "R2", "bits in reset", edge_bits, 0);
    rst = 1'b0;
    n = 0;
    noisy = 1'b0;
    while (!edge_valid && n < 40) begin
      @(negedge clk);
      n++;
      if (!edge_valid && edge_bits != 2'b00) noisy = 1'b1;
    end
    check(n == 20, "R1", "edges until valid", n, 20);
    check(noisy == 1'b0, "R2", "bits while invalid", noisy, 0);

    for (int v = 0; v < NVEC; v++) begin
      real exp_sp;
      load_word(VEC[v][63:32]);
      repeat (60) @(negedge clk);
      measure(rises, highs, min_sp, max_sp, splits, bad_mid);
      exp_sp = 2.0 * 4294967296.0 / real'(VEC[v][63:32]);
      check(rises >= int'(VEC[v][31:0]) - 1 && rises <= int'(VEC[v][31:0]) + 1,
            "R3", "rising edges", rises, VEC[v][31:0]);
      check(highs * 10 >= 2 * WIN * 4 && highs * 10 <= 2 * WIN * 6,
            "R7", "high slots", highs, WIN);
      check(real'(min_sp) >= exp_sp - 2.0 && real'(max_sp) <= exp_sp + 2.0,
            "R8", "edge spacing max", max_sp, longint'(exp_sp));
      check(bad_mid == 0, "R5", "mid edge continuity", bad_mid, 0);
      if (v == 2) begin
        check(splits > 0, "R6", "mid-clock edges", splits, 1);
        // R9: with 5.5-clock period both placements must occur
        check(splits < rises * 2, "R9", "early placements present", splits, rises);
      end
    end

    // R4: change input without strobe; period stays 100 clocks
    tune_word = 32'd67108864;
    repeat (60) @(negedge clk);
    measure(rises, highs, min_sp, max_sp, splits, bad_mid);
    check(rises >= 19 && rises <= 21, "R4", "ignored word", rises, 20);
    load_word(32'd67108864);
    repeat (60) @(negedge clk);
    measure(rises, highs, min_sp, max_sp, splits, bad_mid);
    check(rises >= 30 && rises <= 32, "R4", "loaded word", rises, 31);

    // R1: reset during operation
    rst = 1'b1;
    @(negedge clk);
    check(edge_valid == 1'b0, "R1", "valid after mid reset", edge_valid, 0);
    check(edge_bits == 2'b00, "R2", "bits after mid reset", edge_bits, 0);
    rst = 1'b0;
    repeat (25) @(negedge clk);
    check(edge_valid == 1'b1, "R1", "valid after refill", edge_valid, 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule